// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer reached through a small 16-bit register interface. All writes that change its behaviour are refused until the lock register has been opened with a fixed key. Writing any other value to the lock register closes it again. The 32-bit reload value is written as two 16-bit words. The upper word is staged first. Writing the lower word transfers the whole value into the down-counter and starts a short busy window, during which further load writes are dropped.

The counter runs while its enable bit is set. When it reaches zero, the raw interrupt status is set. If the interrupt is enabled, the counter restarts from the last loaded value. Otherwise the counter parks at zero, and if reset is enabled it emits a single-cycle reset request. The masked interrupt output is the raw status gated by the interrupt enable. Software removes a pending interrupt by writing the clear register.

The counter is controlled by a three-state machine:
- CS_STOP: idle.
- CS_RUN: counting.
- CS_HALT: expired in reset mode.

Its transitions are:
- start: CS_STOP to CS_RUN, when enable is set.
- pause: CS_RUN to CS_STOP, when enable is cleared.
- reload: CS_RUN to CS_RUN, on expiry with the interrupt enabled.
- expire: CS_RUN to CS_HALT, on expiry with the interrupt disabled.
- rearm: CS_HALT to CS_STOP, on an accepted load.

The load path has a second machine with two states, LS_IDLE and LS_BUSY. Its transitions are:
- accept: LS_IDLE to LS_BUSY, on an accepted lower-word write.
- drain: LS_BUSY to LS_IDLE, once the busy window has elapsed.

Top module: `wdk_top`

## Requirements
- R1: After reset the lock reads 1 (locked), the control register reads 0, the counter reads 0, status reads 0, and irq and rst_req are 0.
- R2: Writing 0xE551 to address 5 unlocks; lock reads 0. Writing any other value to address 5 locks; lock reads 1. Writes to address 5 are always accepted.
- R3: While locked, writes to control (address 0), load-high (1), load-low (2) and clear (4) have no effect.
- R4: A write to address 2 while unlocked and not busy loads {load-high, written word} into the counter and the reload register. The counter reads back at address 6 (upper word) and address 7 (lower word). Address 2 reads back the lower word of the reload register.
- R5: Status bit 1 (busy) is 1 for exactly 4 cycles after an accepted load. While busy, writes to addresses 1 and 2 are ignored and the counter holds its value.
- R6: Control bit 0 enables counting. The counter decrements by one per cycle while enabled and not busy. Clearing the bit holds the value.
- R7: When a running counter is at zero, status bit 0 (raw) is set. If control bit 1 (interrupt enable) is 1, the counter reloads the last loaded value on the next cycle.
- R8: When expiry occurs with control bit 1 at 0, the counter stays at zero and stops. If control bit 2 (reset enable) is 1, rst_req is 1 for exactly one cycle. No further pulse occurs until a new load.
- R9: irq equals raw AND control bit 1. Status bit 2 reports the same value.
- R10: Writing a word with bit 0 set to address 4 clears raw on that edge. An expiry on the same edge takes priority.
- R11: A write to address 1 only stages the upper word. The counter does not change until the lower word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| irq | output | 1 | Masked interrupt |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench targets the following corner cases:
- A load write issued on the cycle right after an accepted load must be dropped. A design that accepts it would overwrite the counter.
- The busy window must be exactly four cycles long. An off-by-one shows up as a wrong count of status samples.
- Reset mode must produce a single pulse. A design that keeps re-expiring at zero would produce a train of pulses.
- After relocking, the clear register and the load registers are written again. A lock that guards only some registers would let these writes through.
- A behavioural model is compared with irq, rst_req and the addressed read data on every clock. This catches expiry and reload timing that is off by one cycle.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam int AW = 3;
    localparam int DW = 16;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_HI   = 3'd1;
    localparam logic [AW-1:0] A_LO   = 3'd2;
    localparam logic [AW-1:0] A_STAT = 3'd3;
    localparam logic [AW-1:0] A_CLR  = 3'd4;
    localparam logic [AW-1:0] A_LOCK = 3'd5;
    localparam logic [AW-1:0] A_CNTH = 3'd6;
    localparam logic [AW-1:0] A_CNTL = 3'd7;

    localparam int CB_EN  = 0;
    localparam int CB_IE  = 1;
    localparam int CB_RE  = 2;
    localparam int CTRL_W = 3;

    typedef enum logic [1:0] {CS_STOP, CS_RUN, CS_HALT} cnt_state_e;
    typedef enum logic {LS_IDLE, LS_BUSY} ld_state_e;
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
    import wdk_pkg::*;
#(
    parameter logic [DW-1:0] KEY = 16'hE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic              busy,
    output logic              locked,
    output logic [CTRL_W-1:0] ctrl,
    output logic [DW-1:0]     hi_stage,
    output logic              load_go,
    output logic              clr_go
);
    logic open_wr;
    assign open_wr = wr_en && !locked;
    assign load_go = open_wr && (addr == A_LO) && !busy;
    assign clr_go  = open_wr && (addr == A_CLR) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked   <= 1'b1;
            ctrl     <= '0;
            hi_stage <= '0;
        end else begin
            if (wr_en && addr == A_LOCK)
                locked <= (wdata != KEY);
            if (open_wr && addr == A_CTRL)
                ctrl <= wdata[CTRL_W-1:0];
            if (open_wr && addr == A_HI && !busy)
                hi_stage <= wdata;
        end
    end

    p_locked_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && addr == A_CTRL) |=> $stable(ctrl));
    p_locked_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && addr == A_HI) |=> $stable(hi_stage));
    p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LOCK && wdata == KEY) |=> !locked);
    p_other_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LOCK && wdata != KEY) |=> locked);
endmodule

// File: rtl/wdk_loader.sv
module wdk_loader
    import wdk_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_go,
    output logic busy
);
    localparam int BW = (BUSY_CYC > 2) ? $clog2(BUSY_CYC) : 1;

    ld_state_e      state, nstate;
    logic [BW-1:0]  left, nleft;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LS_IDLE;
            left  <= '0;
        end else begin
            state <= nstate;
            left  <= nleft;
        end
    end

    always_comb begin
        nstate = state;
        nleft  = left;
        unique case (state)
            LS_IDLE: if (load_go) begin
                nstate = LS_BUSY;
                nleft  = BW'(BUSY_CYC - 1);
            end
            LS_BUSY: if (left == '0) nstate = LS_IDLE;
                     else nleft = left - 1'b1;
            default: nstate = LS_IDLE;
        endcase
    end

    assign busy = (state == LS_BUSY);

    logic [7:0] run_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 8'd1;
        else           run_len <= '0;
    end

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 8'(BUSY_CYC)));
    p_go_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |-> !busy);
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
    import wdk_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_go,
    input  logic [CW-1:0] load_val,
    input  logic          cnt_en,
    input  logic          ie,
    input  logic          re,
    input  logic          clr_go,
    input  logic          busy,
    output logic [CW-1:0] count,
    output logic [CW-1:0] reload,
    output logic          raw,
    output logic          rst_req
);
    cnt_state_e    state, nstate;
    logic [CW-1:0] n_cnt, n_rel;
    logic          n_raw, n_rst, expire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= CS_STOP;
            count   <= '0;
            reload  <= '0;
            raw     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            state   <= nstate;
            count   <= n_cnt;
            reload  <= n_rel;
            raw     <= n_raw;
            rst_req <= n_rst;
        end
    end

    always_comb begin
        nstate = state;
        n_cnt  = count;
        n_rel  = reload;
        n_rst  = 1'b0;
        expire = 1'b0;
        if (load_go) begin
            n_cnt = load_val;
            n_rel = load_val;
            if (state == CS_HALT) nstate = CS_STOP;
        end else begin
            unique case (state)
                CS_STOP: if (cnt_en) nstate = CS_RUN;
                CS_RUN: begin
                    if (!cnt_en) nstate = CS_STOP;
                    else if (!busy) begin
                        if (count == '0) begin
                            expire = 1'b1;
                            if (ie) n_cnt = reload;
                            else begin
                                nstate = CS_HALT;
                                n_rst  = re;
                            end
                        end else begin
                            n_cnt = count - 1'b1;
                        end
                    end
                end
                CS_HALT: nstate = CS_HALT;
                default: nstate = CS_STOP;
            endcase
        end
        n_raw = raw;
        if (clr_go) n_raw = 1'b0;
        if (expire) n_raw = 1'b1;
    end

    p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    p_rst_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (!$past(ie) && $past(re)));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !load_go) |=> $stable(count));
    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load_go) |=> $stable(count));
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ie) |=> (count == $past(reload)));
    p_raw_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw);
endmodule

// File: rtl/wdk_top.sv
module wdk_top
    import wdk_pkg::*;
#(
    parameter logic [DW-1:0] KEY      = 16'hE551,
    parameter int            BUSY_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq,
    output logic          rst_req
);
    localparam int CW = 2 * DW;

    logic              locked, busy, load_go, clr_go, raw;
    logic [CTRL_W-1:0] ctrl;
    logic [DW-1:0]     hi_stage;
    logic [CW-1:0]     count, reload;

    wdk_regs #(.KEY(KEY)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .locked(locked), .ctrl(ctrl), .hi_stage(hi_stage),
        .load_go(load_go), .clr_go(clr_go)
    );

    wdk_loader #(.BUSY_CYC(BUSY_CYC)) u_loader (
        .clk(clk), .rst_n(rst_n), .load_go(load_go), .busy(busy)
    );

    wdk_counter #(.CW(CW)) u_counter (
        .clk(clk), .rst_n(rst_n), .load_go(load_go),
        .load_val({hi_stage, wdata}), .cnt_en(ctrl[CB_EN]), .ie(ctrl[CB_IE]),
        .re(ctrl[CB_RE]), .clr_go(clr_go), .busy(busy), .count(count),
        .reload(reload), .raw(raw), .rst_req(rst_req)
    );

    assign irq = raw & ctrl[CB_IE];

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: rdata[CTRL_W-1:0] = ctrl;
            A_HI:   rdata = hi_stage;
            A_LO:   rdata = reload[DW-1:0];
            A_STAT: rdata[2:0] = {irq, busy, raw};
            A_CLR:  rdata = '0;
            A_LOCK: rdata[0] = locked;
            A_CNTH: rdata = count[CW-1:DW];
            A_CNTL: rdata = count[DW-1:0];
            default: rdata = '0;
        endcase
    end

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq |-> raw) and (!ctrl[CB_IE] |-> !irq));
    p_reset_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (locked && !irq && !rst_req && count == '0));
endmodule

// File: tb/tb_wdk_top.sv
module tb_wdk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        irq, rst_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wdk_top dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req));

    // Behavioural reference model
    bit          m_locked = 1;
    bit [2:0]    m_ctrl = 0;
    bit [15:0]   m_hi = 0;
    bit [31:0]   m_cnt = 0, m_rel = 0;
    int          m_busy = 0;
    int          m_st = 0;   // 0 stopped, 1 running, 2 parked at zero
    bit          m_raw = 0, m_rst = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_locked = 1; m_ctrl = 0; m_hi = 0; m_cnt = 0; m_rel = 0;
            m_busy = 0; m_st = 0; m_raw = 0; m_rst = 0;
        end else begin
            bit ld, clr, ex, nr;
            ld  = wr_en && addr == 3'd2 && !m_locked && m_busy == 0;
            clr = wr_en && addr == 3'd4 && !m_locked && wdata[0];
            ex = 0; nr = 0;
            if (ld) begin
                m_cnt = {m_hi, wdata}; m_rel = m_cnt;
                if (m_st == 2) m_st = 0;
            end else if (m_st == 0) begin
                if (m_ctrl[0]) m_st = 1;
            end else if (m_st == 1) begin
                if (!m_ctrl[0]) m_st = 0;
                else if (m_busy == 0) begin
                    if (m_cnt == 0) begin
                        ex = 1;
                        if (m_ctrl[1]) m_cnt = m_rel;
                        else begin m_st = 2; nr = m_ctrl[2]; end
                    end else m_cnt = m_cnt - 1;
                end
            end
            if (clr) m_raw = 0;
            if (ex) m_raw = 1;
            m_rst = nr;
            if (wr_en && !m_locked && addr == 3'd0) m_ctrl = wdata[2:0];
            if (wr_en && !m_locked && addr == 3'd1 && m_busy == 0) m_hi = wdata;
            if (ld) m_busy = 4; else if (m_busy > 0) m_busy--;
            if (wr_en && addr == 3'd5) m_locked = (wdata != 16'hE551);
        end
    end

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {13'd0, m_ctrl};
            3'd1: return m_hi;
            3'd2: return m_rel[15:0];
            3'd3: return {13'd0, m_raw && m_ctrl[1], m_busy > 0, m_raw};
            3'd5: return {15'd0, m_locked};
            3'd6: return m_cnt[31:16];
            3'd7: return m_cnt[15:0];
            default: return 16'd0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            checks += 3;
            if (irq !== (m_raw && m_ctrl[1])) begin
                errors++;
                $display("FAIL R9 irq: actual %0b expected %0b", irq, m_raw && m_ctrl[1]);
            end
            if (rst_req !== m_rst) begin
                errors++;
                $display("FAIL R8 rst_req: actual %0b expected %0b", rst_req, m_rst);
            end
            if (rdata !== m_read(addr)) begin
                errors++;
                $display("FAIL R4/R6 readback addr %0d: actual %h expected %h",
                         addr, rdata, m_read(addr));
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        addr = a; #1; v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, a, b, prev;
        int n, pulses;
        bit seen;
        idle(3);
        rst_n = 1;
        idle(1);
        rd(3'd5, v); chk("R1 lock after reset", v, 16'd1);
        rd(3'd0, v); chk("R1 ctrl after reset", v, 16'd0);
        rd(3'd3, v); chk("R1 status after reset", v, 16'd0);
        rd(3'd7, v); chk("R1 counter after reset", v, 16'd0);
        chk("R1 irq/rst_req after reset", {14'd0, irq, rst_req}, 16'd0);

        wr(3'd0, 16'd7);
        rd(3'd0, v); chk("R3 ctrl write while locked", v, 16'd0);
        wr(3'd5, 16'hE551);
        rd(3'd5, v); chk("R2 unlock with key", v, 16'd0);

        wr(3'd1, 16'h0001);
        rd(3'd6, v); chk("R11 high write alone", v, 16'd0);
        wr(3'd2, 16'h0005);
        rd(3'd6, v); chk("R4 counter high", v, 16'h0001);
        rd(3'd7, v); chk("R4 counter low", v, 16'h0005);
        wr(3'd2, 16'h0099);
        rd(3'd7, v); chk("R5 load during busy ignored", v, 16'h0005);
        idle(6);

        wr(3'd2, 16'h000A);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            rd(3'd3, v);
            if (!v[1]) break;
            n++;
            idle(1);
        end
        chk("R5 busy length", 16'(n), 16'd4);

        wr(3'd0, 16'd1);
        idle(3);
        wr(3'd0, 16'd0);
        rd(3'd7, a);
        idle(5);
        rd(3'd7, b);
        chk("R6 hold when disabled", b, a);
        checks++;
        if (a == 16'h000A) begin
            errors++;
            $display("FAIL R6 counting: actual %h expected below 000a", a);
        end

        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h0003);
        idle(5);
        wr(3'd0, 16'd5);
        pulses = 0;
        for (int i = 0; i < 30; i++) begin
            if (rst_req) pulses++;
            idle(1);
        end
        chk("R8 single reset pulse", 16'(pulses), 16'd1);
        rd(3'd7, v); chk("R8 parked at zero", v, 16'd0);
        rd(3'd3, v); chk("R7 raw set on expiry", v & 16'd1, 16'd1);
        chk("R9 irq masked in reset mode", {15'd0, irq}, 16'd0);

        wr(3'd4, 16'd1);
        rd(3'd3, v); chk("R10 clear raw", v & 16'd1, 16'd0);

        wr(3'd0, 16'd3);
        wr(3'd2, 16'h0002);
        pulses = 0; seen = 0; prev = 16'd1;
        for (int i = 0; i < 30; i++) begin
            rd(3'd7, v);
            if (prev == 16'd0 && v == 16'd2) seen = 1;
            prev = v;
            if (rst_req) pulses++;
            idle(1);
        end
        chk("R7 reload after expiry", {15'd0, seen}, 16'd1);
        chk("R8 no pulse in interrupt mode", 16'(pulses), 16'd0);
        chk("R9 irq asserted", {15'd0, irq}, 16'd1);
        rd(3'd3, v); chk("R9 masked status bit", v & 16'd4, 16'd4);

        wr(3'd0, 16'd1);
        chk("R9 irq gated off", {15'd0, irq}, 16'd0);

        wr(3'd5, 16'h1234);
        rd(3'd5, v); chk("R2 relock", v, 16'd1);
        wr(3'd4, 16'd1);
        rd(3'd3, v); chk("R3 clear while locked", v & 16'd1, 16'd1);
        wr(3'd1, 16'hABCD);
        rd(3'd1, v); chk("R3 high write while locked", v, 16'd0);
        wr(3'd2, 16'h0007);
        rd(3'd2, v); chk("R3 low write while locked", v, 16'h0002);
        idle(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule